// File: doc/BRIEF.md
# Accumulator ALU with Four-Flag Status

This block is the arithmetic core of a small 8-bit processor. The accumulator is always the left operand. The right operand comes from a register or an immediate byte. A 5-bit operation code selects one of 23 functions: binary arithmetic and logic, unary accumulator operations, shifts and rotates, carry manipulation, and a read of the status flags. The result is combinational. A write-enable tells the surrounding datapath whether the accumulator should take the result.

The four status flags are negative, overflow, zero and carry. They sit in a register that changes only on a clock edge where `op_valid` is high. The current carry feeds add-with-carry, subtract-with-borrow and the two rotates through carry. Fetching operands, sequencing and branching on the flags all belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry) produce A+B and A+B+C modulo 256. Carry becomes the unsigned carry out. Overflow is set when the signed sum falls outside -128..127. Op 0 ignores the incoming carry.
- R2: Op 2 (subtract) and op 3 (subtract with borrow) produce A-B and A-B-C modulo 256. Carry becomes 1 when the exact difference is negative (borrow). Overflow reports signed overflow.
- R3: Op 7 (compare) updates all four flags exactly as op 2 would and never asserts `acc_we_o`.
- R4: Ops 4, 5 and 6 (AND, OR, XOR) write the bitwise result and clear carry and overflow, whatever carry was before.
- R5: The unary ops act on A only:
  - op 8 is increment: carry is the carry out, overflow is set for 0x7F.
  - op 9 is decrement: carry is the borrow, overflow is set for 0x80.
  - op 10 is bitwise NOT: carry and overflow are cleared.
  - op 11 is negate (0-A): carry is set for any nonzero A, overflow is set for 0x80.
- R6: The plain shifts all load carry with the bit shifted out:
  - op 12 shifts left and inserts 0; overflow is cleared.
  - op 13 shifts right logically and inserts 0.
  - op 14 shifts left and inserts 0; overflow is set when bit 7 changes.
  - op 15 shifts right arithmetically and keeps bit 7.
  - Every shift except op 14 clears overflow.
- R7: Op 16 rotates left within 8 bits and op 17 rotates right within 8 bits. Carry receives the bit that wraps around. Overflow is cleared.
- R8: Op 18 rotates left through carry and op 19 rotates right through carry, as a 9-bit ring. The old carry enters at bit 0 (op 18) or bit 7 (op 19). The bit shifted out becomes the new carry.
- R9: For every op from 0 to 19, zero is set when the 8-bit result is 0 and negative equals result bit 7.
- R10: Op 20 sets carry and op 21 inverts carry. Neither changes the other three flags or asserts `acc_we_o`.
- R11: Op 22 drives the result {4'b0000, N, V, Z, C} (carry in bit 0, zero in bit 1, overflow in bit 2, negative in bit 3) with `acc_we_o` high, and leaves the flags unchanged.
- R12: After reset `flags_o` is 0000. Flags change only on a clock edge with `op_valid` high. Op codes 23 to 31, and any op with `op_valid` low, leave the flags unchanged and keep `acc_we_o` low. `flags_o` is packed as {N, V, Z, C} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_valid | input | 1 | Operation is issued this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator (left operand) |
| opnd_i | input | 8 | Second operand (register or immediate) |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | Accumulator should take `result_o` |
| flags_o | output | 4 | Registered flags {N, V, Z, C} |

## Verification
The bench sweeps every accumulator value against sixteen edge-heavy operands, with carry both set and clear, and compares each result and flag with integer arithmetic. The signed boundaries 0x7F/0x80 and 0x00/0xFF are included:
- A design that uses carry instead of borrow on subtraction would flip carry on every subtract, compare, decrement and negate.
- A design that forgets the old carry would corrupt the add-with-carry, subtract-with-borrow and through-carry rotates only when carry is set.
- Swapped rotate variants would show up as a wrong bit 0 or bit 7.
- An arithmetic right shift that inserts 0 would fail every negative input.

Flag reads after varied flag states catch a mis-packed status byte. Idle cycles, unused codes and compare catch a flags register or write-enable that leaks when it must hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_AND = 5'd4,
        OP_OR  = 5'd5,
        OP_XOR = 5'd6,
        OP_CP  = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_NOT = 5'd10,
        OP_NEG = 5'd11,
        OP_SLL = 5'd12,
        OP_SRL = 5'd13,
        OP_SLA = 5'd14,
        OP_SRA = 5'd15,
        OP_ROL = 5'd16,
        OP_ROR = 5'd17,
        OP_RCL = 5'd18,
        OP_RCR = 5'd19,
        OP_SCF = 5'd20,
        OP_CCF = 5'd21,
        OP_RDF = 5'd22
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_SLL = 3'd0,
        SH_SRL = 3'd1,
        SH_SLA = 3'd2,
        SH_SRA = 3'd3,
        SH_ROL = 3'd4,
        SH_ROR = 3'd5,
        SH_RCL = 3'd6,
        SH_RCR = 3'd7
    } shift_kind_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOT = 2'd3
    } bw_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        alu_flags_t flags;
    } alu_state_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         v_o
);
    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic          cin_eff;
    logic [SW-1:0] wide;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        cin_eff = sub_i ? ~cin_i : cin_i;
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{(SW-1){1'b0}}, cin_eff};
        sum_o   = wide[W-1:0];
        c_o     = sub_i ? ~wide[W] : wide[W];
        v_o     = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/acc_alu_bitwise.sv
module acc_alu_bitwise #(
    parameter int W = 8
) (
    input  acc_alu_pkg::bw_kind_e kind_i,
    input  logic [W-1:0]          a_i,
    input  logic [W-1:0]          b_i,
    output logic [W-1:0]          res_o
);
    import acc_alu_pkg::*;

    always_comb begin
        unique case (kind_i)
            BW_AND:  res_o = a_i & b_i;
            BW_OR:   res_o = a_i | b_i;
            BW_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter #(
    parameter int W = 8
) (
    input  acc_alu_pkg::shift_kind_e kind_i,
    input  logic [W-1:0]             a_i,
    input  logic                     cin_i,
    output logic [W-1:0]             res_o,
    output logic                     c_o,
    output logic                     v_o
);
    import acc_alu_pkg::*;

    logic left;
    logic fill;

    always_comb begin
        left = 1'b0;
        fill = 1'b0;
        v_o  = 1'b0;
        unique case (kind_i)
            SH_SLL: begin left = 1'b1; fill = 1'b0; end
            SH_SLA: begin left = 1'b1; fill = 1'b0; v_o = a_i[W-1] ^ a_i[W-2]; end
            SH_ROL: begin left = 1'b1; fill = a_i[W-1]; end
            SH_RCL: begin left = 1'b1; fill = cin_i; end
            SH_SRL: begin left = 1'b0; fill = 1'b0; end
            SH_SRA: begin left = 1'b0; fill = a_i[W-1]; end
            SH_ROR: begin left = 1'b0; fill = a_i[0]; end
            default: begin left = 1'b0; fill = cin_i; end
        endcase
        if (left) begin
            res_o = {a_i[W-2:0], fill};
            c_o   = a_i[W-1];
        end else begin
            res_o = {fill, a_i[W-1:1]};
            c_o   = a_i[0];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] result_o,
    output logic         acc_we_o,
    output logic [3:0]   flags_o
);
    import acc_alu_pkg::*;

    localparam int FW  = $bits(alu_flags_t);
    localparam int PAD = W - FW;

    alu_op_e     op;
    alu_state_t  state_d, state_q;

    logic [W-1:0] as_a, as_b, as_sum;
    logic         as_cin, as_sub, as_c, as_v;
    bw_kind_e     bw_kind;
    logic [W-1:0] bw_res;
    shift_kind_e  sh_kind;
    logic [W-1:0] sh_res;
    logic         sh_c, sh_v;

    logic [W-1:0] res;
    logic         we;

    assign op = alu_op_e'(op_i);

    // Operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = acc_i;
        as_b   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = state_q.flags.c;
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = state_q.flags.c; end
            OP_INC: as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin as_b = {{(W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
            OP_NEG: begin as_a = '0; as_b = acc_i; as_sub = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_OR:   bw_kind = BW_OR;
            OP_XOR:  bw_kind = BW_XOR;
            OP_NOT:  bw_kind = BW_NOT;
            default: bw_kind = BW_AND;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_SRL:  sh_kind = SH_SRL;
            OP_SLA:  sh_kind = SH_SLA;
            OP_SRA:  sh_kind = SH_SRA;
            OP_ROL:  sh_kind = SH_ROL;
            OP_ROR:  sh_kind = SH_ROR;
            OP_RCL:  sh_kind = SH_RCL;
            OP_RCR:  sh_kind = SH_RCR;
            default: sh_kind = SH_SLL;
        endcase
    end

    acc_alu_addsub #(.W(W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .c_o   (as_c),
        .v_o   (as_v)
    );

    acc_alu_bitwise #(.W(W)) u_bitwise (
        .kind_i (bw_kind),
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .res_o  (bw_res)
    );

    acc_alu_shifter #(.W(W)) u_shifter (
        .kind_i (sh_kind),
        .a_i    (acc_i),
        .cin_i  (state_q.flags.c),
        .res_o  (sh_res),
        .c_o    (sh_c),
        .v_o    (sh_v)
    );

    // Next-state and result computation
    always_comb begin
        alu_flags_t nx;
        logic       upd_zn;
        nx     = state_q.flags;
        res    = '0;
        we     = 1'b0;
        upd_zn = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP,
            OP_INC, OP_DEC, OP_NEG: begin
                res    = as_sum;
                nx.c   = as_c;
                nx.v   = as_v;
                upd_zn = 1'b1;
                we     = (op != OP_CP);
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                res    = bw_res;
                nx.c   = 1'b0;
                nx.v   = 1'b0;
                upd_zn = 1'b1;
                we     = 1'b1;
            end
            OP_SLL, OP_SRL, OP_SLA, OP_SRA,
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                res    = sh_res;
                nx.c   = sh_c;
                nx.v   = sh_v;
                upd_zn = 1'b1;
                we     = 1'b1;
            end
            OP_SCF: nx.c = 1'b1;
            OP_CCF: nx.c = ~state_q.flags.c;
            OP_RDF: begin
                res = {{PAD{1'b0}}, state_q.flags};
                we  = 1'b1;
            end
            default: ;
        endcase
        if (upd_zn) begin
            nx.z = (res == '0);
            nx.n = res[W-1];
        end
        state_d       = state_q;
        if (op_valid) begin
            state_d.flags = nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = res;
    assign acc_we_o = op_valid & we;
    assign flags_o  = state_q.flags;

    // R12: idle cycles keep the flags
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_o));

    // R10: set-carry raises carry and leaves N, V, Z alone
    a_r10_scf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_i == 5'd20) |=> (flags_o[0] && $stable(flags_o[3:1])));

    // R10: complement-carry inverts carry
    a_r10_ccf_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_i == 5'd21) |=> (flags_o[0] != $past(flags_o[0])));

    // R3: compare never writes the accumulator
    a_r3_cp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_i == 5'd7) |-> !acc_we_o);

    // R9: written results set zero and negative from the value
    a_r9_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we_o && op_i != 5'd22) |=>
            (flags_o[1] == ($past(result_o) == '0)) && (flags_o[3] == $past(result_o[W-1])));

    // R11: flag read shows the stored flags with a zero upper field
    a_r11_rdf_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_i == 5'd22) |-> (result_o == {{PAD{1'b0}}, flags_o}));

    // R12: unused codes keep the flags and never write
    a_r12_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_i > 5'd22) |-> !acc_we_o ##1 $stable(flags_o));

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] result_o;
    logic       acc_we_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit pend = 0;
    logic [3:0] mf = 4'h0;
    logic [3:0] exp_f = 4'h0;
    string cur_tag = "R12";

    always #2.5 clk = ~clk;

    acc_alu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .result_o (result_o),
        .acc_we_o (acc_we_o),
        .flags_o  (flags_o)
    );

    function automatic string tag(input int op);
        if (op <= 1) return "R1";
        if (op <= 3) return "R2";
        if (op == 7) return "R3";
        if (op <= 6) return "R4";
        if (op <= 11) return "R5";
        if (op <= 15) return "R6";
        if (op <= 17) return "R7";
        if (op <= 19) return "R8";
        if (op <= 21) return "R10";
        if (op == 22) return "R11";
        return "R12";
    endfunction

    // Reference model; flags packed {N,V,Z,C}. Z and N per R9.
    function automatic void model(input int op, input int a, input int b,
                                  input logic [3:0] fi, output int r,
                                  output bit we, output logic [3:0] fo);
        int c  = int'(fi[0]);
        int sa = (a > 127) ? a - 256 : a;
        int sb = (b > 127) ? b - 256 : b;
        int s  = 0;
        int sv = 0;
        bit zn = 0;
        bit cc = 0;
        bit vv = 0;
        fo = fi; r = 0; we = 0;
        case (op)
            0, 1: begin
                s = a + b + ((op == 1) ? c : 0); sv = sa + sb + ((op == 1) ? c : 0);
                cc = (s > 255); vv = (sv > 127 || sv < -128); r = s & 255; zn = 1; we = 1;
            end
            2, 3, 7: begin
                s = a - b - ((op == 3) ? c : 0); sv = sa - sb - ((op == 3) ? c : 0);
                cc = (s < 0); vv = (sv > 127 || sv < -128); r = s & 255; zn = 1; we = (op != 7);
            end
            4: begin r = a & b; zn = 1; we = 1; end
            5: begin r = a | b; zn = 1; we = 1; end
            6: begin r = a ^ b; zn = 1; we = 1; end
            10: begin r = 255 - a; zn = 1; we = 1; end
            8: begin s = a + 1; sv = sa + 1; cc = (s > 255); vv = (sv > 127); r = s & 255; zn = 1; we = 1; end
            9: begin s = a - 1; sv = sa - 1; cc = (s < 0); vv = (sv < -128); r = s & 255; zn = 1; we = 1; end
            11: begin s = 0 - a; sv = 0 - sa; cc = (s < 0); vv = (sv > 127); r = s & 255; zn = 1; we = 1; end
            12: begin r = (a * 2) & 255; cc = (a >= 128); zn = 1; we = 1; end
            14: begin r = (a * 2) & 255; cc = (a >= 128); sv = sa * 2; vv = (sv > 127 || sv < -128); zn = 1; we = 1; end
            13: begin r = a / 2; cc = (a % 2 == 1); zn = 1; we = 1; end
            15: begin r = a / 2 + ((a >= 128) ? 128 : 0); cc = (a % 2 == 1); zn = 1; we = 1; end
            16: begin r = ((a * 2) & 255) + ((a >= 128) ? 1 : 0); cc = (a >= 128); zn = 1; we = 1; end
            17: begin r = a / 2 + (a % 2) * 128; cc = (a % 2 == 1); zn = 1; we = 1; end
            18: begin r = ((a * 2) & 255) + c; cc = (a >= 128); zn = 1; we = 1; end
            19: begin r = a / 2 + c * 128; cc = (a % 2 == 1); zn = 1; we = 1; end
            20: fo[0] = 1'b1;
            21: fo[0] = ~fi[0];
            22: begin r = int'(fi); we = 1; end
            default: ;
        endcase
        if (zn) fo = {(r >= 128), vv, (r == 0), cc};
    endfunction

    task automatic chk_flags();
        checks++;
        if (flags_o !== exp_f) begin
            errors++;
            $display("FAIL %s (flags, Z/N per R9): flags_o=%b expected=%b", cur_tag, flags_o, exp_f);
        end
        mf = exp_f;
        pend = 0;
    endtask

    task automatic do_op(input int op, input int a, input int b, input bit v);
        int r;
        bit we;
        logic [3:0] fo;
        @(negedge clk);
        if (pend) chk_flags();
        if (v) model(op, a, b, mf, r, we, fo);
        else begin r = 0; we = 0; fo = mf; end
        op_valid = v;
        op_i     = op[4:0];
        acc_i    = a[7:0];
        opnd_i   = b[7:0];
        cur_tag  = v ? tag(op) : "R12";
        #1;
        checks++;
        if (acc_we_o !== we) begin
            errors++;
            $display("FAIL %s (write enable) op=%0d a=%02h b=%02h: acc_we_o=%b expected=%b",
                     cur_tag, op, a, b, acc_we_o, we);
        end
        if (we) begin
            checks++;
            if (result_o !== r[7:0]) begin
                errors++;
                $display("FAIL %s (result) op=%0d a=%02h b=%02h cin=%b: result_o=%02h expected=%02h",
                         cur_tag, op, a, b, mf[0], result_o, r[7:0]);
            end
        end
        exp_f = fo;
        pend  = 1;
    endtask

    task automatic set_carry(input bit cin);
        if (mf[0] != cin) do_op(21, 0, 0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int blist[16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h3F, 8'h40, 8'h7E,
                          8'h7F, 8'h80, 8'h81, 8'hAA, 8'h55, 8'hC0, 8'hFE, 8'hFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        checks++;
        if (flags_o !== 4'h0) begin
            errors++;
            $display("FAIL R12 (reset flags): flags_o=%b expected=0000", flags_o);
        end
        rst_n = 1'b1;

        // R1 R2 R3 R4: binary ops, carry clear and set
        for (int cin = 0; cin < 2; cin++)
            for (int op = 0; op < 8; op++)
                for (int a = 0; a < 256; a++)
                    for (int k = 0; k < 16; k++) begin
                        set_carry(cin[0]);
                        do_op(op, a, blist[k], 1'b1);
                    end

        // R5 R6 R7 R8: unary and shift ops with both carry values
        for (int cin = 0; cin < 2; cin++)
            for (int op = 8; op < 20; op++)
                for (int a = 0; a < 256; a++) begin
                    set_carry(cin[0]);
                    do_op(op, a, (a * 29) & 255, 1'b1);
                end

        // R10 R11 R12: carry ops, flag read and unused codes after varied flags
        for (int i = 0; i < 256; i++) begin
            do_op(i % 4, i, (i * 37 + 11) & 255, 1'b1);
            do_op(20 + (i % 12), i, 255 - i, 1'b1);
            do_op(22, 0, 0, 1'b1);
        end

        // R12: idle cycles with every op code leave flags untouched
        for (int i = 0; i < 128; i++) begin
            do_op((i * 7) % 32, (i * 3) & 255, 8'h80, 1'b0);
            if (i % 8 == 0) do_op(2, i, 8'h7F, 1'b1);
        end

        @(negedge clk);
        if (pend) chk_flags();
        op_valid = 1'b0;
        finish_run();
    end

endmodule